// File: doc/BRIEF.md
# DDR Data Strobe Direction Sequencer

This block decides, cycle by cycle, which way the data and strobe pins of a DDR SDRAM interface point on the controller side. It sees one-cycle READ and WRITE issue pulses from the command path and a programmable CAS latency. From these it produces output enables for every data pin and every byte-lane strobe, the level each strobe is driven to, and a capture-window flag. The capture-window flag tells the read datapath when the strobes coming back from the memory carry valid data.

The interface has 64 data bits plus an 8-bit check lane, so there are nine byte lanes with one strobe each. When nothing is happening, the data pins float and the strobes are driven low so that they cannot drift high. A write starts with one cycle of strobe held low (the preamble). Four cycles of strobe toggling follow, with data driven alongside. A read keeps the strobes driven low until the CAS latency has elapsed. It then releases them for four cycles, which is a burst of eight, and raises the capture-window flag for the same four cycles. Quarter-cycle timing is not modelled. An abstract half-cycle flag says whether the current half of the clock is the rising (positive-capture) half, and a toggling strobe simply follows it.

Top module: `ddr_dqs_dir_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, every strobe output enable is 1, every data output enable is 0, every strobe output is 0, and the capture window and busy are 0.
- R2: When idle, the data pins are released (enables 0), the strobes are driven (enables 1) to level 0, and the capture window is 0.
- R3: A WRITE accepted at clock edge n gives a preamble in the cycle after edge n: strobes driven at level 0, and data enables still 0.
- R4: After edges n+1 through n+4 of an accepted WRITE, all data enables and all strobe enables are 1, and every strobe output equals the half-cycle flag: 1 in the rising half, 0 in the falling half. After edge n+5 the block is idle.
- R5: A READ accepted at edge n with effective latency m keeps the strobes driven low after edges n through n+m-1. After edges n+m through n+m+3 it sets every strobe enable to 0 and the capture window to 1. Data enables stay 0 throughout.
- R6: The CAS latency input is sampled only in the cycle a READ is accepted. The values 0 and 1 are treated as 2, and 2 to 7 are used as given. Changes during a read have no effect.
- R7: Busy is 1 from the edge after a command is accepted until the sequence ends. A READ or WRITE pulse seen while busy is 1 is dropped and changes no output.
- R8: If READ and WRITE pulse in the same idle cycle, the READ is performed and the WRITE is dropped.
- R9: The strobe enables are 0 exactly in the cycles where the capture window is 1, and otherwise 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_issue | input | 1 | One-cycle READ command pulse |
| wr_issue | input | 1 | One-cycle WRITE command pulse |
| cas_lat | input | 3 | CAS latency in cycles (0 and 1 read as 2) |
| half_rise | input | 1 | Abstract half-cycle flag, 1 during the rising half |
| dq_oe | output | 72 | Per-pin data output enable, 8 pins per lane |
| dqs_oe | output | 9 | Per-lane strobe output enable |
| dqs_out | output | 9 | Per-lane strobe level while driven |
| rd_capture | output | 1 | Read capture window, incoming strobes valid |
| busy | output | 1 | Sequence in progress, new commands dropped |

## Verification
The bench builds the block with its default parameters: nine lanes of eight pins, a burst of eight, and a 3-bit latency field. With these, every latency code from 0 to 7 is reachable, including the two codes that are clamped and the longest read window. Sequences are checked against a counter-based model on every clock, in both halves of the clock. The stimulus includes commands dropped while busy, simultaneous READ and WRITE, a latency change in the middle of a read, and commands issued back to back at the first idle cycle.

// File: rtl/ddr_dir_pkg.sv
package ddr_dir_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_WR_PRE   = 3'd1,
        PH_WR_BURST = 3'd2,
        PH_RD_WAIT  = 3'd3,
        PH_RD_WIN   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2
    } cmd_e;

    typedef struct packed {
        logic drive_data;
        logic drive_strobe;
        logic toggle;
    } lane_ctl_t;

    localparam int unsigned MIN_CL = 2;

    function automatic int unsigned eff_latency(input int unsigned raw);
        return (raw < MIN_CL) ? MIN_CL : raw;
    endfunction

    function automatic lane_ctl_t decode_phase(input phase_e ph);
        lane_ctl_t c;
        c = '{drive_data: 1'b0, drive_strobe: 1'b1, toggle: 1'b0};
        case (ph)
            PH_WR_BURST: c = '{drive_data: 1'b1, drive_strobe: 1'b1, toggle: 1'b1};
            PH_RD_WIN:   c = '{drive_data: 1'b0, drive_strobe: 1'b0, toggle: 1'b0};
            default:     c = '{drive_data: 1'b0, drive_strobe: 1'b1, toggle: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dqs_cmd_pick.sv
module dqs_cmd_pick
    import ddr_dir_pkg::*;
(
    input  logic rd_req,
    input  logic wr_req,
    input  logic seq_busy,
    output cmd_e cmd
);
    always_comb begin
        cmd = CMD_NONE;
        if (!seq_busy) begin
            if (rd_req)      cmd = CMD_RD;
            else if (wr_req) cmd = CMD_WR;
        end
    end
endmodule

// File: rtl/dqs_phase_seq.sv
module dqs_phase_seq
    import ddr_dir_pkg::*;
#(
    parameter int unsigned CL_W  = 3,
    parameter int unsigned BEATS = 4,
    localparam int unsigned CL_MAX = (1 << CL_W) - 1,
    localparam int unsigned SPAN   = (CL_MAX > BEATS) ? CL_MAX : BEATS,
    localparam int unsigned CNT_W  = $clog2(SPAN + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  cmd_e            cmd,
    input  logic [CL_W-1:0] cas_lat,
    output phase_e          phase,
    output logic            seq_busy
);
    phase_e           ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    int unsigned      lat;

    localparam logic [CNT_W-1:0] BURST_LAST = CNT_W'(BEATS - 1);

    always_comb begin
        lat   = eff_latency(int'(cas_lat));
        ph_d  = ph_q;
        cnt_d = cnt_q;
        case (ph_q)
            PH_IDLE: begin
                if (cmd == CMD_RD) begin
                    ph_d  = PH_RD_WAIT;
                    cnt_d = CNT_W'(lat - 1);
                end else if (cmd == CMD_WR) begin
                    ph_d  = PH_WR_PRE;
                    cnt_d = '0;
                end
            end
            PH_WR_PRE: begin
                ph_d  = PH_WR_BURST;
                cnt_d = BURST_LAST;
            end
            PH_WR_BURST: begin
                if (cnt_q == '0) ph_d = PH_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
            PH_RD_WAIT: begin
                if (cnt_q == '0) begin
                    ph_d  = PH_RD_WIN;
                    cnt_d = BURST_LAST;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_RD_WIN: begin
                if (cnt_q == '0) ph_d = PH_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
            default: begin
                ph_d  = PH_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    assign phase    = ph_q;
    assign seq_busy = (ph_q != PH_IDLE);
endmodule

// File: rtl/dqs_lane_ctl.sv
module dqs_lane_ctl
    import ddr_dir_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input  lane_ctl_t        ctl,
    input  logic             half_rise,
    output logic [PINS-1:0]  pin_oe,
    output logic             strobe_oe,
    output logic             strobe_lvl
);
    assign pin_oe     = {PINS{ctl.drive_data}};
    assign strobe_oe  = ctl.drive_strobe;
    assign strobe_lvl = ctl.toggle & half_rise;
endmodule

// File: rtl/ddr_dqs_dir_seq.sv
module ddr_dqs_dir_seq
    import ddr_dir_pkg::*;
#(
    parameter int unsigned LANES     = 9,
    parameter int unsigned LANE_PINS = 8,
    parameter int unsigned BURST_LEN = 8,
    parameter int unsigned CL_W      = 3,
    localparam int unsigned PIN_W    = LANES * LANE_PINS,
    localparam int unsigned BEATS    = BURST_LEN / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_issue,
    input  logic              wr_issue,
    input  logic [CL_W-1:0]   cas_lat,
    input  logic              half_rise,
    output logic [PIN_W-1:0]  dq_oe,
    output logic [LANES-1:0]  dqs_oe,
    output logic [LANES-1:0]  dqs_out,
    output logic              rd_capture,
    output logic              busy
);
    cmd_e      cmd;
    phase_e    phase;
    logic      seq_busy;
    lane_ctl_t ctl;

    dqs_cmd_pick u_pick (
        .rd_req   (rd_issue),
        .wr_req   (wr_issue),
        .seq_busy (seq_busy),
        .cmd      (cmd)
    );

    dqs_phase_seq #(.CL_W(CL_W), .BEATS(BEATS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .cas_lat  (cas_lat),
        .phase    (phase),
        .seq_busy (seq_busy)
    );

    assign ctl = decode_phase(phase);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dqs_lane_ctl #(.PINS(LANE_PINS)) u_lane (
            .ctl        (ctl),
            .half_rise  (half_rise),
            .pin_oe     (dq_oe[g*LANE_PINS +: LANE_PINS]),
            .strobe_oe  (dqs_oe[g]),
            .strobe_lvl (dqs_out[g])
        );
    end

    assign rd_capture = (phase == PH_RD_WIN);
    assign busy       = seq_busy;
endmodule

// File: rtl/ddr_dqs_dir_seq_chk.sv
module ddr_dqs_dir_seq_chk #(
    parameter int unsigned PIN_W = 72,
    parameter int unsigned LANES = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_issue,
    input logic             wr_issue,
    input logic [PIN_W-1:0] dq_oe,
    input logic [LANES-1:0] dqs_oe,
    input logic             rd_capture,
    input logic             busy
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!busy && !rd_capture && dq_oe == '0 && &dqs_oe));

    p_preamble_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_issue && !rd_issue && !busy) |=> (busy && dq_oe == '0 && &dqs_oe));

    p_burst_full_r4: assert property (@(posedge clk) disable iff (rst)
        (|dq_oe) |-> (&dq_oe && &dqs_oe && busy));

    p_read_no_drive_r5: assert property (@(posedge clk) disable iff (rst)
        rd_capture |-> (dq_oe == '0 && busy));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dq_oe == '0 && &dqs_oe && !rd_capture));

    p_read_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_issue && !busy) |=> (busy && dq_oe == '0 && &dqs_oe));

    p_release_window_r9: assert property (@(posedge clk) disable iff (rst)
        rd_capture ? (dqs_oe == '0) : (&dqs_oe));

    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_capture && !$past(rd_capture)) |-> $past(busy));
endmodule

bind ddr_dqs_dir_seq ddr_dqs_dir_seq_chk #(.PIN_W(PIN_W), .LANES(LANES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_issue   (rd_issue),
    .wr_issue   (wr_issue),
    .dq_oe      (dq_oe),
    .dqs_oe     (dqs_oe),
    .rd_capture (rd_capture),
    .busy       (busy)
);

// File: tb/ddr_dqs_dir_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_dqs_dir_seq_tb_top;
    localparam int LANES = 9;
    localparam int PINS  = 8;
    localparam int PIN_W = LANES * PINS;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rd_issue = 1'b0;
    logic             wr_issue = 1'b0;
    logic [2:0]       cas_lat = 3'd2;
    logic             half_rise = 1'b0;
    logic [PIN_W-1:0] dq_oe;
    logic [LANES-1:0] dqs_oe;
    logic [LANES-1:0] dqs_out;
    logic             rd_capture;
    logic             busy;

    always #2 clk = ~clk;

    ddr_dqs_dir_seq dut_i (
        .clk(clk), .rst(rst), .rd_issue(rd_issue), .wr_issue(wr_issue),
        .cas_lat(cas_lat), .half_rise(half_rise), .dq_oe(dq_oe),
        .dqs_oe(dqs_oe), .dqs_out(dqs_out), .rd_capture(rd_capture), .busy(busy)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // Behavioural model: 0 idle, 1 write, 2 read; age counts edges since acceptance
    int m_mode = 0;
    int m_age  = 0;
    int m_lat  = 2;

    task automatic model_edge(input bit rd, input bit wr, input int cl, input bit r);
        if (r) begin
            m_mode = 0; m_age = 0;
        end else if (m_mode != 0) begin
            m_age++;
            if ((m_mode == 1 && m_age == 5) || (m_mode == 2 && m_age == m_lat + 4)) m_mode = 0;
        end else if (rd) begin
            m_mode = 2; m_age = 0; m_lat = (cl < 2) ? 2 : cl;
        end else if (wr) begin
            m_mode = 1; m_age = 0;
        end
    endtask

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_now();
        bit win, wdrive;
        win    = (m_mode == 2) && (m_age >= m_lat);
        wdrive = (m_mode == 1) && (m_age >= 1);
        chk(cur_req, "busy",       128'(busy),       128'(m_mode != 0));
        chk(cur_req, "rd_capture", 128'(rd_capture), 128'(win));
        chk("R9",    "dqs_oe",     128'(dqs_oe),     win ? 128'(0) : 128'({LANES{1'b1}}));
        chk(cur_req, "dq_oe",      128'(dq_oe),      wdrive ? 128'({PIN_W{1'b1}}) : 128'(0));
        half_rise = 1'b1; #0.2;
        chk(cur_req, "dqs_out_rise", 128'(dqs_out), wdrive ? 128'({LANES{1'b1}}) : 128'(0));
        half_rise = 1'b0; #0.2;
        chk(cur_req, "dqs_out_fall", 128'(dqs_out), 128'(0));
    endtask

    // Drive inputs for one edge (called at negedge), advance model, compare at next negedge
    task automatic cyc(input bit rd, input bit wr, input int cl);
        rd_issue = rd; wr_issue = wr; cas_lat = 3'(cl);
        model_edge(rd, wr, cl, rst);
        @(posedge clk);
        @(negedge clk);
        rd_issue = 1'b0; wr_issue = 1'b0;
        compare_now();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, int'(cas_lat));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: state during and right after reset
        cur_req = "R1";
        compare_now();
        cyc(0, 0, 2);
        cyc(1, 1, 5);   // commands under reset ignored
        rst = 1'b0;
        cyc(0, 0, 2);
        // R2: idle stays quiet
        cur_req = "R2";
        idle(3);
        // R3 / R4: plain write, preamble then four toggling cycles
        cur_req = "R3";
        cyc(0, 1, 2);
        cur_req = "R4";
        idle(6);
        // R5: reads across latencies
        cur_req = "R5";
        for (int cl = 2; cl <= 7; cl++) begin
            cyc(1, 0, cl);
            idle(cl + 5);
        end
        // R6: clamped codes and latency change during a read
        cur_req = "R6";
        cyc(1, 0, 0); idle(7);
        cyc(1, 0, 1); idle(7);
        cyc(1, 0, 3);
        cyc(0, 0, 7); cyc(0, 0, 0); idle(6);
        // R7: commands while busy dropped
        cur_req = "R7";
        cyc(0, 1, 4);
        cyc(1, 0, 2); cyc(0, 1, 2); cyc(1, 1, 6); idle(4);
        cyc(1, 0, 4);
        cyc(0, 1, 2); idle(4); cyc(1, 0, 2); cyc(0, 1, 2); idle(4);
        // R8: simultaneous read and write
        cur_req = "R8";
        cyc(1, 1, 3); idle(8);
        // back-to-back at first idle cycle
        cur_req = "R4";
        cyc(0, 1, 2); idle(5); cyc(1, 0, 2); idle(6); cyc(0, 1, 2); idle(6);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule